// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block models the command side of a serial NOR flash device. It holds the status register and decides whether each command that could change the device may run. It sits behind an SPI slave front end in mode 0. Bits are sampled on the rising edge of the serial clock and driven on the falling edge, most significant bit first. The serial pins are sampled by the system clock, so the serial clock must run several times slower than `clk`.

A transaction starts when chip select goes low and is decoded when chip select returns high. At that point the control logic checks four things: that the frame has the right length, that the write latch is set, that no cycle is busy, and that the protection rules allow the command. An accepted write-status, program or erase cycle raises the busy flag for a parameterised number of system clocks. When the cycle ends, the busy flag falls and the write latch clears.

The status read command is never blocked. It streams a fresh copy of the status byte every eight serial clocks for as long as chip select stays low.

Top module: `sflash_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and `spiMiso` is 0.
- R2: An accepted cycle holds WIP (bit 0) at 1 for exactly `BUSY_CYCLES` system clocks. WIP is 0 at all other times.
- R3: While WEL (bit 1) is 0, these commands are ignored: write-status 0x01, program 0x02, sector erase 0xD8 and bulk erase 0xC7. Ignored means no status change and no busy cycle.
- R4: Write-enable 0x06 sets WEL and write-disable 0x04 clears it. Each takes effect only when the frame is exactly 8 bits long.
- R5: After command 0x05, the status byte is shifted out MSB first, one bit per falling edge of the serial clock. It is re-captured and sent again every 8 clocks while chip select stays low. This works even while WIP is 1.
- R6: The status byte layout is {SRWD[7], 0[6], TB[5], BP2[4], BP1[3], BP0[2], WEL[1], WIP[0]}. Bit 6 always reads 0.
- R7: Write-status takes 16 bits in total. It loads SRWD from data bit 7, TB from bit 5 and BP from bits 4:2. It is rejected when SRWD is 1 and `wpN` is low. A rejection leaves the bits unchanged and clears WEL.
- R8: A BP value k > 0 protects 2^(k-1)/64 of the address space, and k = 7 protects all of it. The protected region is at the top when TB is 0 and at the bottom when TB is 1. Program and sector erase commands that address the region are rejected, and the rejection clears WEL.
- R9: Bulk erase (8 bits) is accepted only when BP is 0. Otherwise it is rejected and WEL clears.
- R10: While WIP is 1, every command except the status read is ignored.
- R11: WEL clears in the same cycle that an accepted cycle completes.
- R12: A command is decoded when chip select rises. Sector erase needs exactly 32 bits. Program needs at least 32 bits, in a multiple of 8. Any other frame length is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiClk | input | 1 | Serial clock, mode 0 |
| spiCsN | input | 1 | Chip select, active low |
| spiMosi | input | 1 | Serial data in |
| spiMiso | output | 1 | Serial data out, 0 when no status read is active |
| wpN | input | 1 | Write-protect pin, active low |

## Verification
Status reads are taken in several conditions: right after reset, while a cycle is busy, and as a two-byte continuous stream. Together these separate a one-shot read from a repeating one, and a snapshot taken at the start of each byte from a stale one.

The protection checks use sector and program addresses on each side of the region boundary, for both TB settings and for BP values 2 and 7. This exposes off-by-one errors in the boundary and a swapped top/bottom selection.

Frames that are too short or too long, commands sent while WEL is 0, and commands sent while busy must all leave the status byte unchanged. Bulk erase is tried with BP set and with BP cleared.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam logic [7:0] CMD_RD_STAT  = 8'h05;
  localparam logic [7:0] CMD_WR_EN    = 8'h06;
  localparam logic [7:0] CMD_WR_DIS   = 8'h04;
  localparam logic [7:0] CMD_WR_STAT  = 8'h01;
  localparam logic [7:0] CMD_PROG     = 8'h02;
  localparam logic [7:0] CMD_SEC_ERS  = 8'hD8;
  localparam logic [7:0] CMD_BULK_ERS = 8'hC7;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
  } ctlStrobe_t;
endpackage

// File: rtl/sflash_dp.sv
module sflash_dp
  import sflash_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csN,
  input  logic             mosi,
  input  logic             wip,
  input  ctlStrobe_t       strobe,
  output logic             miso,
  output logic             cmdEnd,
  output logic [7:0]       opcode,
  output logic [CNT_W-1:0] bitCnt,
  output logic             wel,
  output logic             srwd,
  output logic [2:0]       bpVal,
  output logic             protHit,
  output logic [7:0]       statusByte
);
  localparam int HDR_BITS    = 8 + ADDR_W;
  localparam int REGION_BITS = 6;
  localparam int REGION_CNT  = 1 << REGION_BITS;
  localparam int IDX_W       = REGION_BITS + 1;

  logic sclkQ, csQ, sclkRise, sclkFall;
  logic [HDR_BITS-1:0] shiftReg, nextShift;
  logic [ADDR_W-1:0] addrReg;
  logic rdActive, misoReg, tbBit;
  logic [2:0] outIdx;
  logic [7:0] snap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
    end
  end

  assign sclkRise  = sclk & ~sclkQ & ~csN;
  assign sclkFall  = ~sclk & sclkQ & ~csN;
  assign cmdEnd    = csN & ~csQ;
  assign nextShift = {shiftReg[HDR_BITS-2:0], mosi};

  // serial shifter, frame counter and status streaming
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      opcode   <= '0;
      addrReg  <= '0;
      rdActive <= 1'b0;
      outIdx   <= 3'd7;
      snap     <= '0;
      misoReg  <= 1'b0;
    end else if (csN) begin
      bitCnt   <= '0;
      rdActive <= 1'b0;
      outIdx   <= 3'd7;
      misoReg  <= 1'b0;
    end else if (sclkRise) begin
      shiftReg <= nextShift;
      if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      if (bitCnt == CNT_W'(7)) begin
        opcode   <= nextShift[7:0];
        rdActive <= (nextShift[7:0] == CMD_RD_STAT);
      end
      if (bitCnt == CNT_W'(HDR_BITS - 1)) addrReg <= nextShift[ADDR_W-1:0];
    end else if (sclkFall && rdActive) begin
      if (outIdx == 3'd7) begin
        snap    <= statusByte;
        misoReg <= statusByte[7];
      end else begin
        misoReg <= snap[outIdx];
      end
      outIdx <= outIdx - 3'd1;
    end
  end

  // status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel   <= 1'b0;
      srwd  <= 1'b0;
      tbBit <= 1'b0;
      bpVal <= '0;
    end else begin
      if (strobe.setWel) wel <= 1'b1;
      else if (strobe.clrWel) wel <= 1'b0;
      if (strobe.loadStat) begin
        srwd  <= shiftReg[7];
        tbBit <= shiftReg[5];
        bpVal <= shiftReg[4:2];
      end
    end
  end

  assign statusByte = {srwd, 1'b0, tbBit, bpVal, wel, wip};
  assign miso       = misoReg;

  // protected region decode
  logic [IDX_W-1:0] blkIdx, nProt;
  assign blkIdx = {1'b0, addrReg[ADDR_W-1 -: REGION_BITS]};

  always_comb begin
    case (bpVal)
      3'd0:    nProt = '0;
      3'd7:    nProt = IDX_W'(REGION_CNT);
      default: nProt = IDX_W'(1) << (bpVal - 3'd1);
    endcase
    if (tbBit) protHit = (blkIdx < nProt);
    else       protHit = (blkIdx >= (IDX_W'(REGION_CNT) - nProt));
  end
endmodule

// File: rtl/sflash_ctl.sv
module sflash_ctl
  import sflash_pkg::*;
#(
  parameter int BUSY_CYCLES = 64,
  parameter int CNT_W       = 12,
  parameter int HDR_BITS    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdEnd,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             wel,
  input  logic             srwd,
  input  logic             wpN,
  input  logic [2:0]       bpVal,
  input  logic             protHit,
  output logic             wip,
  output ctlStrobe_t       strobe
);
  localparam int TMR_W = $clog2(BUSY_CYCLES + 1);

  logic [TMR_W-1:0] tmr;
  logic isMod, blocked, acceptNow, lenByte, lenStat, lenAddr, lenProg;

  assign lenByte = (bitCnt == CNT_W'(8));
  assign lenStat = (bitCnt == CNT_W'(16));
  assign lenAddr = (bitCnt == CNT_W'(HDR_BITS));
  assign lenProg = (bitCnt >= CNT_W'(HDR_BITS)) && (bitCnt[2:0] == 3'd0);

  always_comb begin
    isMod   = 1'b0;
    blocked = 1'b0;
    case (opcode)
      CMD_WR_STAT:  begin isMod = lenStat; blocked = srwd & ~wpN;     end
      CMD_PROG:     begin isMod = lenProg; blocked = protHit;         end
      CMD_SEC_ERS:  begin isMod = lenAddr; blocked = protHit;         end
      CMD_BULK_ERS: begin isMod = lenByte; blocked = (bpVal != 3'd0); end
      default: ;
    endcase
  end

  assign acceptNow = cmdEnd && !wip && isMod && wel && !blocked;

  always_comb begin
    strobe = '0;
    if (cmdEnd && !wip) begin
      if (opcode == CMD_WR_EN && lenByte) strobe.setWel = 1'b1;
      if (opcode == CMD_WR_DIS && lenByte) strobe.clrWel = 1'b1;
      if (isMod && wel && blocked) strobe.clrWel = 1'b1;
      if (acceptNow && opcode == CMD_WR_STAT) strobe.loadStat = 1'b1;
    end
    if (wip && tmr == '0) strobe.clrWel = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wip <= 1'b0;
      tmr <= '0;
    end else if (acceptNow) begin
      wip <= 1'b1;
      tmr <= TMR_W'(BUSY_CYCLES - 1);
    end else if (wip) begin
      if (tmr == '0) wip <= 1'b0;
      else           tmr <= tmr - 1'b1;
    end
  end
endmodule

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
  import sflash_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int BUSY_CYCLES = 64,
  parameter int CNT_W       = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiCsN,
  input  logic spiMosi,
  output logic spiMiso,
  input  logic wpN
);
  localparam int HDR_BITS = 8 + ADDR_W;

  ctlStrobe_t       strobe;
  logic             wip, cmdEnd, wel, srwd, protHit;
  logic [7:0]       opcode, statusByte;
  logic [CNT_W-1:0] bitCnt;
  logic [2:0]       bpVal;

  sflash_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .sclk(spiClk), .csN(spiCsN), .mosi(spiMosi),
    .wip(wip), .strobe(strobe), .miso(spiMiso), .cmdEnd(cmdEnd),
    .opcode(opcode), .bitCnt(bitCnt), .wel(wel), .srwd(srwd),
    .bpVal(bpVal), .protHit(protHit), .statusByte(statusByte)
  );

  sflash_ctl #(.BUSY_CYCLES(BUSY_CYCLES), .CNT_W(CNT_W), .HDR_BITS(HDR_BITS)) ctl_i (
    .clk(clk), .rstN(rstN), .cmdEnd(cmdEnd), .opcode(opcode), .bitCnt(bitCnt),
    .wel(wel), .srwd(srwd), .wpN(wpN), .bpVal(bpVal), .protHit(protHit),
    .wip(wip), .strobe(strobe)
  );
endmodule

// File: rtl/sflash_chk.sv
module sflash_chk #(
  parameter int BUSY_CYCLES = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic [7:0] statusByte
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (statusByte[0]) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  a_r2_wip_bounded: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] |-> busyRun < RUN_W'(BUSY_CYCLES));

  a_r2_wip_full: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[0]) |-> busyRun == RUN_W'(BUSY_CYCLES));

  a_r3_wel_needed: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[0]) |-> $past(statusByte[1]));

  a_r7_hw_lock: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[7] && !wpN) |=> $stable(statusByte[7:2]));

  a_r11_wel_clear_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[0]) |-> !statusByte[1]);
endmodule

bind sflash_status_ctrl sflash_chk #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .wpN(wpN), .statusByte(statusByte)
);

// File: tb/sflash_status_ctrl_tb_top.sv
module sflash_status_ctrl_tb_top;
  localparam int BUSY = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiClk = 1'b0;
  logic spiCsN = 1'b1;
  logic spiMosi = 1'b0;
  logic wpN = 1'b1;
  logic spiMiso;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] s0, s1;

  always #10 clk = ~clk;

  sflash_status_ctrl #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .wpN(wpN)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (3) @(negedge clk);
  endtask

  task automatic spiXfer(input logic [63:0] data, input int nBits);
    @(negedge clk);
    spiCsN = 1'b0;
    for (int i = nBits - 1; i >= 0; i--) begin
      spiMosi = data[i];
      halfWait();
      spiClk = 1'b1;
      halfWait();
      spiClk = 1'b0;
    end
    halfWait();
    spiCsN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readStatus(input int nBytes, output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] got = '0;
    @(negedge clk);
    spiCsN = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      spiMosi = 1'(8'h05 >> i);
      halfWait();
      spiClk = 1'b1;
      halfWait();
      spiClk = 1'b0;
    end
    for (int i = 0; i < nBytes * 8; i++) begin
      halfWait();
      got = {got[14:0], spiMiso};
      spiClk = 1'b1;
      halfWait();
      spiClk = 1'b0;
    end
    halfWait();
    spiCsN = 1'b1;
    repeat (4) @(negedge clk);
    if (nBytes == 2) begin b0 = got[15:8]; b1 = got[7:0]; end
    else begin b0 = got[7:0]; b1 = got[7:0]; end
  endtask

  task automatic waitIdle();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  task automatic expectStatus(input string tag, input logic [7:0] exp);
    logic [7:0] a, b;
    readStatus(1, a, b);
    check(tag, a, exp);
  endtask

  task automatic wrEn();  spiXfer(64'h06, 8); endtask
  task automatic wrDis(); spiXfer(64'h04, 8); endtask
  task automatic wrStat(input logic [7:0] v); spiXfer({48'h0, 8'h01, v}, 16); endtask
  task automatic secErase(input logic [23:0] a); spiXfer({32'h0, 8'hD8, a}, 32); endtask
  task automatic program1(input logic [23:0] a); spiXfer({24'h0, 8'h02, a, 8'hA5}, 40); endtask

  task automatic testReset();
    check("R1 miso idle", {7'h0, spiMiso}, 8'h00);
    expectStatus("R1 R6 reset status", 8'h00);
  endtask

  task automatic testLatch();
    wrEn();  expectStatus("R4 write enable", 8'h02);
    wrDis(); expectStatus("R4 write disable", 8'h00);
    spiXfer(64'h0C, 9); expectStatus("R4 R12 9-bit enable ignored", 8'h00);
    wrStat(8'h1C); expectStatus("R3 write status without WEL", 8'h00);
    secErase(24'h000000); expectStatus("R3 erase without WEL", 8'h00);
  endtask

  task automatic testWriteStatus();
    wrEn();
    wrStat(8'hDC);
    readStatus(2, s0, s1);
    check("R2 R5 R6 busy read byte0", s0, 8'h9F);
    check("R5 repeated byte1", s1, 8'h9F);
    waitIdle();
    expectStatus("R2 R11 completed write status", 8'h9C);
  endtask

  task automatic testHwLock();
    wpN = 1'b0;
    wrEn(); wrStat(8'h00);
    expectStatus("R7 locked write status rejected", 8'h9C);
    wpN = 1'b1;
    wrEn(); secErase(24'h000000);
    expectStatus("R8 bp7 whole array protected", 8'h9C);
    wrEn(); wrStat(8'h08); waitIdle();
    expectStatus("R7 unlocked write status", 8'h08);
  endtask

  task automatic testRegions();
    wrEn(); secErase(24'hFFF000);
    expectStatus("R8 top region erase rejected", 8'h08);
    wrEn(); secErase(24'h000000);
    expectStatus("R8 erase outside region", 8'h0B);
    waitIdle();
    wrEn(); program1(24'hF7FFFF);
    expectStatus("R8 R12 program below boundary", 8'h0B);
    waitIdle();
    wrEn(); program1(24'hF80000);
    expectStatus("R8 program at boundary rejected", 8'h08);
    wrEn(); wrStat(8'h28); waitIdle();
    expectStatus("R7 set bottom region", 8'h28);
    wrEn(); secErase(24'h07FFFF);
    expectStatus("R8 bottom region rejected", 8'h28);
    wrEn(); secErase(24'h080000);
    expectStatus("R8 above bottom region", 8'h2B);
    waitIdle();
  endtask

  task automatic testBulk();
    wrEn(); spiXfer(64'hC7, 8);
    expectStatus("R9 bulk erase with BP set", 8'h28);
    wrEn(); wrStat(8'h00); waitIdle();
    wrEn(); spiXfer(64'hC7, 8);
    expectStatus("R9 bulk erase accepted", 8'h03);
    waitIdle();
    expectStatus("R9 R11 bulk erase done", 8'h00);
  endtask

  task automatic testBusyIgnore();
    wrEn(); wrStat(8'h14);
    wrDis(); wrStat(8'h00);
    expectStatus("R10 commands ignored while busy", 8'h17);
    waitIdle();
    expectStatus("R10 R2 state after busy", 8'h14);
  endtask

  task automatic testFraming();
    wrEn(); spiXfer(64'hD80000, 24);
    expectStatus("R12 short erase frame ignored", 8'h16);
    spiXfer({24'h0, 8'h02, 24'h000000, 8'hA5} >> 4, 36);
    expectStatus("R12 odd program frame ignored", 8'h16);
    wrDis();
    expectStatus("R4 final disable", 8'h14);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testLatch();
    testWriteStatus();
    testHwLock();
    testRegions();
    testBulk();
    testBusyIgnore();
    testFraming();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule